// File: doc/BRIEF.md
# Multicast Hash Filter Table

This block decides whether a received frame whose destination is a group address should be kept. It holds a 64-bit hash table as two 32-bit words. For each destination address it computes a reflected CRC-32 over the six address bytes, reverses the bit order of the 32-bit result, and uses the six most significant bits of the reversed value as a table index. The top bit selects the word and the next five bits select the bit inside that word. The table bit at that index is the accept decision.

A host programs the table through a small register port. It can replace either word with a full 32-bit value, clear the whole table, or set one table bit by handing over a reversed 32-bit hash. The receive path presents a destination address with a one-cycle strobe. The match flag comes back on a result port exactly two cycles later. Addresses whose group bit is clear never match here, because individual addresses are filtered elsewhere.

Top module: `mc_hash_filter`

## Requirements
- R1: The hash is a CRC-32 with reflected polynomial 0xEDB88320. It starts from all ones and has no final inversion. It runs over the six address bytes in the order `lk_daddr[47:40]` first down to `lk_daddr[7:0]` last, with each byte taken least significant bit first.
- R2: The 32-bit CRC is bit-reversed, so CRC bit i lands at position 31-i. Bit 31 of the reversed value selects table word 0 or 1. Bits 30..26 select the bit inside that word.
- R3: `res_valid` is high in exactly the cycle two clock edges after a cycle with `lk_valid` high, and is low in every other cycle. Back-to-back strobes give back-to-back results.
- R4: When the group bit `lk_daddr[40]` is clear, `res_match` is 0 whatever the table holds.
- R5: After reset both table words read as zero.
- R6: `reg_op` = 2 (clear) sets both words to zero on the next edge.
- R7: `reg_op` = 3 (set by hash) treats `reg_wdata` as a reversed hash and ORs in the single table bit chosen by `reg_wdata[31]` and `reg_wdata[30:26]`. Every other bit is left unchanged, and `reg_wdata[25:0]` is ignored.
- R8: `reg_op` = 1 (write) replaces word `reg_sel` with `reg_wdata` on the next edge, and leaves the other word unchanged. `reg_op` = 0 does nothing.
- R9: `reg_rdata` always shows the current contents of word `reg_sel`.
- R10: A register command given in the same cycle as a lookup strobe is seen by that lookup. A command given one cycle after the strobe is not seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup strobe |
| lk_daddr | input | 48 | Destination address, first byte in bits 47:40 |
| res_valid | output | 1 | Lookup result strobe, two cycles after `lk_valid` |
| res_match | output | 1 | Accept decision for the address |
| reg_op | input | 2 | Command: 0 none, 1 write word, 2 clear, 3 set by hash |
| reg_sel | input | 1 | Word select for write and read |
| reg_wdata | input | 32 | Write data, or reversed hash for set |
| reg_rdata | output | 32 | Contents of word `reg_sel` |

## Verification
The table is loaded in several ways and the hashing path is driven against each load. Setting single bits from hashes the bench computes shows that the CRC, the bit reversal and the word/bit split line up. Writing dense patterns such as alternating bits and all ones, then sweeping random group addresses, exposes index errors that a sparse table would hide. Unicast addresses sent against a full table separate the group-bit gate from the table read. Lookups placed beside register commands in the same cycle, and one cycle later, pin down which table state a lookup sees.

// File: rtl/mhf_pkg.sv
package mhf_pkg;

    localparam int ADDR_W      = 48;
    localparam int ADDR_BYTES  = ADDR_W / 8;
    localparam int WORD_W      = 32;
    localparam int NUM_WORDS   = 2;
    localparam int CRC_W       = 32;
    localparam int BIT_SEL_W   = $clog2(WORD_W);
    localparam int WORD_SEL_W  = $clog2(NUM_WORDS);
    localparam int IDX_W       = WORD_SEL_W + BIT_SEL_W;
    localparam int TABLE_W     = WORD_W * NUM_WORDS;
    localparam int GROUP_BIT   = ADDR_W - 8;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB8_8320;
    localparam logic [CRC_W-1:0] CRC_INIT = '1;

    typedef enum logic [1:0] {
        OP_NONE     = 2'd0,
        OP_WRITE    = 2'd1,
        OP_CLEAR    = 2'd2,
        OP_SET_HASH = 2'd3
    } mhf_op_e;

    typedef struct packed {
        logic [WORD_SEL_W-1:0] word;
        logic [BIT_SEL_W-1:0]  bit_pos;
    } mhf_idx_t;

    typedef struct packed {
        logic     valid;
        logic     group;
        mhf_idx_t idx;
    } mhf_probe_t;

    // Reflected CRC over the address bytes, first byte in the top bits.
    function automatic logic [CRC_W-1:0] crc_reflect(input logic [ADDR_W-1:0] a);
        logic [CRC_W-1:0] c;
        logic [7:0]       byt;
        c = CRC_INIT;
        for (int b = 0; b < ADDR_BYTES; b++) begin
            byt = a[ADDR_W-1-8*b -: 8];
            for (int k = 0; k < 8; k++) begin
                if (c[0] ^ byt[k]) c = (c >> 1) ^ CRC_POLY;
                else               c = c >> 1;
            end
        end
        return c;
    endfunction

    function automatic logic [CRC_W-1:0] bit_reverse(input logic [CRC_W-1:0] v);
        logic [CRC_W-1:0] r;
        for (int i = 0; i < CRC_W; i++) r[CRC_W-1-i] = v[i];
        return r;
    endfunction

    // Top bits of a reversed hash pick word then bit.
    function automatic mhf_idx_t hash_to_idx(input logic [CRC_W-1:0] h);
        mhf_idx_t x;
        x.word    = h[CRC_W-1 -: WORD_SEL_W];
        x.bit_pos = h[CRC_W-1-WORD_SEL_W -: BIT_SEL_W];
        return x;
    endfunction

endpackage

// File: rtl/mhf_hash_stage.sv
module mhf_hash_stage
    import mhf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_daddr,
    output mhf_probe_t        probe_q
);

    logic [CRC_W-1:0] crc_raw;
    logic [CRC_W-1:0] crc_rev;
    mhf_probe_t       probe_d;

    always_comb begin
        crc_raw         = crc_reflect(lk_daddr);
        crc_rev         = bit_reverse(crc_raw);
        probe_d.valid   = lk_valid;
        probe_d.group   = lk_daddr[GROUP_BIT];
        probe_d.idx     = hash_to_idx(crc_rev);
    end

    always_ff @(posedge clk) begin
        if (rst) probe_q <= '0;
        else     probe_q <= probe_d;
    end

endmodule

// File: rtl/mhf_table.sv
module mhf_table
    import mhf_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [1:0]            reg_op,
    input  logic [WORD_SEL_W-1:0] reg_sel,
    input  logic [WORD_W-1:0]     reg_wdata,
    output logic [WORD_W-1:0]     reg_rdata,
    output logic [TABLE_W-1:0]    table_q
);

    mhf_op_e                              op;
    mhf_idx_t                             set_idx;
    logic [NUM_WORDS-1:0][WORD_W-1:0]     words_q;

    assign op      = mhf_op_e'(reg_op);
    assign set_idx = hash_to_idx(reg_wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            words_q <= '0;
        end else begin
            unique case (op)
                OP_WRITE:    words_q[reg_sel] <= reg_wdata;
                OP_CLEAR:    words_q <= '0;
                OP_SET_HASH: words_q[set_idx.word][set_idx.bit_pos] <= 1'b1;
                default:     ;
            endcase
        end
    end

    generate
        for (genvar w = 0; w < NUM_WORDS; w++) begin : g_flat
            assign table_q[w*WORD_W +: WORD_W] = words_q[w];
        end
    endgenerate

    assign reg_rdata = words_q[reg_sel];

    // R5
    reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (table_q == '0));

    // R6
    clear_zeroes_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_CLEAR) |=> (table_q == '0));

    // R7
    set_single_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SET_HASH) |=> (($countones(table_q ^ $past(table_q)) <= 1) &&
                                 ((table_q & $past(table_q)) == $past(table_q))));

    // R8
    write_word_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_WRITE) |=> (words_q[$past(reg_sel)] == $past(reg_wdata)));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_NONE) |=> $stable(table_q));

endmodule

// File: rtl/mhf_match_stage.sv
module mhf_match_stage
    import mhf_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  mhf_probe_t         probe_q,
    input  logic [TABLE_W-1:0] table_q,
    output logic               res_valid,
    output logic               res_match
);

    logic [IDX_W-1:0] flat_idx;
    logic             hit;

    assign flat_idx = {probe_q.idx.word, probe_q.idx.bit_pos};
    assign hit      = probe_q.valid & probe_q.group & table_q[flat_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_match <= 1'b0;
        end else begin
            res_valid <= probe_q.valid;
            res_match <= hit;
        end
    end

    // R4
    group_gate_chk: assert property (@(posedge clk) disable iff (rst)
        res_match |-> $past(probe_q.group));

    // R3
    match_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        res_match |-> res_valid);

endmodule

// File: rtl/mc_hash_filter.sv
module mc_hash_filter
    import mhf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        lk_valid,
    input  logic [47:0] lk_daddr,
    output logic        res_valid,
    output logic        res_match,
    input  logic [1:0]  reg_op,
    input  logic [0:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata
);

    mhf_probe_t         probe_q;
    logic [TABLE_W-1:0] table_q;

    mhf_hash_stage u_hash (
        .clk      (clk),
        .rst      (rst),
        .lk_valid (lk_valid),
        .lk_daddr (lk_daddr),
        .probe_q  (probe_q)
    );

    mhf_table u_table (
        .clk       (clk),
        .rst       (rst),
        .reg_op    (reg_op),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .table_q   (table_q)
    );

    mhf_match_stage u_match (
        .clk       (clk),
        .rst       (rst),
        .probe_q   (probe_q),
        .table_q   (table_q),
        .res_valid (res_valid),
        .res_match (res_match)
    );

    // R3
    latency_two_chk: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> ##1 res_valid);

    // R3
    stage_one_valid_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(probe_q.valid));

endmodule

// File: tb/mc_hash_filter_tb.sv
module mc_hash_filter_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 1'b0;
    logic [47:0] lk_daddr = '0;
    logic        res_valid, res_match;
    logic [1:0]  reg_op = 2'd0;
    logic [0:0]  reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    mc_hash_filter u_dut (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_daddr(lk_daddr),
        .res_valid(res_valid), .res_match(res_match), .reg_op(reg_op),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    // Forward (MSB-first) CRC fed the same bit stream yields the reversed hash directly.
    function automatic logic [31:0] ref_hash(input logic [47:0] a);
        logic [31:0] c;
        logic [7:0]  byt;
        logic        fb;
        c = 32'hFFFF_FFFF;
        for (int b = 0; b < 6; b++) begin
            byt = 8'((a >> (40 - 8*b)) & 48'hFF);
            for (int k = 0; k < 8; k++) begin
                fb = c[31] ^ byt[k];
                c  = {c[30:0], 1'b0};
                if (fb) c = c ^ 32'h04C1_1DB7;
            end
        end
        return c;
    endfunction

    function automatic int ref_pos(input logic [31:0] h);
        return (h[31] ? 32 : 0) + int'(h[30:26]);
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference model
    typedef struct { int due; logic [47:0] a; } pend_t;
    pend_t       pq[$];
    pend_t       e;
    logic [63:0] mtab  = '0;
    logic        exp_v = 1'b0;
    logic        exp_m = 1'b0;
    string       exp_req = "R1 R2";

    always @(posedge clk) begin
        if (rst) begin
            mtab  = '0;
            pq.delete();
            exp_v = 1'b0;
            exp_m = 1'b0;
        end else begin
            exp_v = 1'b0;
            exp_m = 1'b0;
            if (pq.size() > 0 && pq[0].due == cyc) begin
                e       = pq.pop_front();
                exp_v   = 1'b1;
                exp_m   = e.a[40] && mtab[ref_pos(ref_hash(e.a))];
                exp_req = e.a[40] ? "R1 R2" : "R4";
            end
            case (reg_op)
                2'd1: mtab[int'(reg_sel)*32 +: 32] = reg_wdata;
                2'd2: mtab = '0;
                2'd3: mtab[ref_pos(reg_wdata)] = 1'b1;
                default: ;
            endcase
            if (lk_valid) pq.push_back('{cyc + 1, lk_daddr});
        end
        cyc++;
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R3", 64'(res_valid), 64'(exp_v));
            if (exp_v) chk(exp_req, 64'(res_match), 64'(exp_m));
            chk("R9", 64'(reg_rdata), 64'(mtab[int'(reg_sel)*32 +: 32]));
        end
    end

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic reg_cmd(input logic [1:0] op, input logic sel, input logic [31:0] wd);
        reg_op = op; reg_sel = sel; reg_wdata = wd;
        step();
        reg_op = 2'd0;
    endtask

    task automatic lookup(input logic [47:0] a);
        lk_valid = 1'b1; lk_daddr = a;
        step();
        lk_valid = 1'b0;
    endtask

    task automatic lookup_expect(input logic [47:0] a, input logic exp, input string req);
        lookup(a);
        step();
        chk(req, {62'd0, res_valid, res_match}, {62'd0, 1'b1, exp});
    endtask

    function automatic logic [47:0] rnd_addr(input logic grp);
        logic [47:0] a;
        a = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
        a[40] = grp;
        return a;
    endfunction

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        done = 1;
        report();
    end

    initial begin
        logic [47:0] a0, a1;
        logic [31:0] h0;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;

        // R5: both words zero after reset
        reg_sel = 1'b0; #1 chk("R5", 64'(reg_rdata), 64'd0);
        reg_sel = 1'b1; #1 chk("R5", 64'(reg_rdata), 64'd0);
        step();

        // R7 / R2: set by hash, then look up that address
        a0 = 48'h0100_5E00_0001;
        h0 = ref_hash(a0);
        reg_cmd(2'd3, 1'b0, h0);
        reg_sel = h0[31]; #1
        chk("R2", 64'(reg_rdata), 64'(32'h1 << h0[30:26]));
        step();
        lookup_expect(a0, 1'b1, "R1");

        // R7: low bits of operand ignored, only one bit added
        reg_cmd(2'd2, 1'b0, 32'h0);
        reg_cmd(2'd3, 1'b0, 32'h0000_0000);
        reg_cmd(2'd3, 1'b0, 32'h03FF_FFFF);
        reg_sel = 1'b0; #1 chk("R7", 64'(reg_rdata), 64'd1);
        reg_sel = 1'b1; #1 chk("R7", 64'(reg_rdata), 64'd0);
        step();
        reg_cmd(2'd3, 1'b0, 32'hFC00_0000);
        reg_sel = 1'b1; #1 chk("R7", 64'(reg_rdata), 64'h8000_0000);
        step();

        // R8: whole-word writes
        reg_cmd(2'd1, 1'b0, 32'hA5A5_0F0F);
        reg_cmd(2'd1, 1'b1, 32'h3C3C_F00F);
        reg_sel = 1'b0; #1 chk("R8", 64'(reg_rdata), 64'hA5A5_0F0F);
        reg_sel = 1'b1; #1 chk("R8", 64'(reg_rdata), 64'h3C3C_F00F);
        step();
        for (int i = 0; i < 200; i++) lookup(rnd_addr(1'b1));
        reg_cmd(2'd1, 1'b0, 32'h5555_5555);
        reg_cmd(2'd1, 1'b1, 32'hAAAA_AAAA);
        for (int i = 0; i < 200; i++) lookup(rnd_addr(1'b1));

        // R4: unicast never matches even with a full table
        reg_cmd(2'd1, 1'b0, 32'hFFFF_FFFF);
        reg_cmd(2'd1, 1'b1, 32'hFFFF_FFFF);
        lookup_expect(48'h0011_2233_4455, 1'b0, "R4");
        lookup_expect(48'h0100_5E7F_FFFA, 1'b1, "R4");
        for (int i = 0; i < 50; i++) lookup(rnd_addr(1'b0));

        // R6: clear empties the table
        reg_cmd(2'd2, 1'b1, 32'hFFFF_FFFF);
        reg_sel = 1'b0; #1 chk("R6", 64'(reg_rdata), 64'd0);
        reg_sel = 1'b1; #1 chk("R6", 64'(reg_rdata), 64'd0);
        step();
        lookup_expect(48'h0100_5E7F_FFFA, 1'b0, "R6");

        // R3: back-to-back strobes with sparse table from hashes
        for (int i = 0; i < 16; i++) begin
            a1 = rnd_addr(1'b1);
            reg_cmd(2'd3, 1'b0, ref_hash(a1));
        end
        for (int i = 0; i < 300; i++) begin
            lk_valid = 1'b1;
            lk_daddr = rnd_addr(($urandom % 4) != 0);
            if (($urandom % 8) == 0) begin
                reg_op = 2'd3; reg_wdata = $urandom;
            end
            step();
            reg_op = 2'd0;
        end
        lk_valid = 1'b0;
        step(); step();

        // R10: command in strobe cycle is seen
        reg_cmd(2'd2, 1'b0, 32'h0);
        a1 = 48'h3300_0000_0101;
        lk_valid = 1'b1; lk_daddr = a1;
        reg_op = 2'd3; reg_wdata = ref_hash(a1);
        step();
        lk_valid = 1'b0; reg_op = 2'd0;
        step();
        chk("R10", {62'd0, res_valid, res_match}, 64'd3);

        // R10: command one cycle later is not seen
        reg_cmd(2'd2, 1'b0, 32'h0);
        lk_valid = 1'b1; lk_daddr = a1;
        step();
        lk_valid = 1'b0;
        reg_op = 2'd3; reg_wdata = ref_hash(a1);
        step();
        reg_op = 2'd0;
        chk("R10", {62'd0, res_valid, res_match}, 64'd2);
        step();
        lookup_expect(a1, 1'b1, "R10");

        repeat (4) step();
        done = 1;
        report();
    end

endmodule